// File: doc/BRIEF.md
# DMA Descriptor Transfer Sequencer

This block runs the transfer described by one channel's descriptor. Each channel has a small descriptor held in a register file inside the block. A descriptor gives a source address, a destination address, a per-minor-loop byte count, an address step, a beginning iteration count and a current iteration count, plus link and interrupt options. When a channel is granted through `start`, the sequencer loads that descriptor into working registers and checks it for consistency. If the descriptor is valid, the block moves 32-bit words by issuing alternating read and write beats on a simple memory request interface that has a ready handshake.

After a minor loop has moved all its bytes, only the advanced source address, the advanced destination address and the decremented current iteration count are stored back into the register file. A minor-loop link request can then follow. When the iteration count runs out, major-loop handling reloads the count from its beginning value. It can also raise a done interrupt and a major-loop link request. A faulty descriptor starts no transfer and gives an error pulse that names the channel. The fault is reported again every time the channel is started, until the descriptor is fixed.

Top module: `dma_desc_seq`

## Requirements
- R1: A `start` pulse while idle loads channel `start_ch`'s descriptor. `busy` rises on the next cycle and stays high until the channel's processing ends. No memory request is made in that first busy cycle. A `start` pulse while busy is ignored.
- R2: A descriptor is faulty when its byte count is zero, its byte count is not a multiple of 4, or its current iteration count is zero. A faulty descriptor causes a one-cycle `err_o` pulse with `err_ch` equal to the channel. It issues no memory request and leaves the stored descriptor unchanged.
- R3: Every start of a channel whose descriptor is still faulty reports the error again.
- R4: A valid descriptor issues exactly byte count / 4 read/write pairs. Each pair reads a word at the current source address and then writes that word to the current destination address. Both addresses advance by the offset after every pair.
- R5: Only one memory access is outstanding at a time. While `mem_req` is high and `mem_rdy` is low, the request, its address and its direction stay unchanged.
- R6: After the minor loop, readback returns a source address and a destination address each advanced by (byte count / 4) × offset, and a current iteration count lowered by one.
- R7: When minor linking is enabled and the lowered iteration count is not zero, `link_o` pulses once with `link_ch` equal to the minor link target, and `done_o` stays low.
- R8: When the iteration count reaches zero, the current count is reloaded from the beginning count. If interrupts are enabled, `done_o` pulses with `done_ch` equal to the channel. If major linking is enabled, `link_o` pulses with the major link target. No minor link is issued in that case.
- R9: When the interrupt and link enables are clear, the channel finishes with no `done_o` or `link_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write a whole descriptor (current count set to beginning count) |
| cfg_ch | input | CHW | Channel being written |
| cfg_src | input | AW | Source byte address |
| cfg_dst | input | AW | Destination byte address |
| cfg_nbytes | input | NW | Bytes per minor loop |
| cfg_step | input | AW | Address step per word |
| cfg_iter | input | IW | Beginning iteration count |
| cfg_irq_en | input | 1 | Raise done at major completion |
| cfg_mnl_en | input | 1 | Minor link enable |
| cfg_mnl_ch | input | CHW | Minor link target |
| cfg_mjl_en | input | 1 | Major link enable |
| cfg_mjl_ch | input | CHW | Major link target |
| rd_ch | input | CHW | Channel selected for readback |
| rd_src | output | AW | Stored source address |
| rd_dst | output | AW | Stored destination address |
| rd_iter | output | IW | Stored current iteration count |
| start | input | 1 | Grant pulse |
| start_ch | input | CHW | Granted channel |
| busy | output | 1 | Sequencer active |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | AW | Beat byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_rdy | input | 1 | Beat accepted |
| done_o | output | 1 | Major-loop done pulse |
| done_ch | output | CHW | Channel of done |
| link_o | output | 1 | Link request pulse |
| link_ch | output | CHW | Link target |
| err_o | output | 1 | Descriptor error pulse |
| err_ch | output | CHW | Channel of error |

## Verification
A wrong fault check shows up in the first cycle after `busy` rises, because a request appears where `err_o` should have pulsed, or the other way round. A wrong address or beat count corrupts destination words, or leaves them untouched, before `busy` falls. It also changes the stored addresses, which the readback shows at once. A wrong iteration count or wrong writeback does not show at the ports until the next start of the channel. That start then fires `done_o` or a link request early or late, so the bench starts each channel more than once.

// File: rtl/dma_desc_seq.sv
module dma_desc_seq #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int NW  = 10,
  parameter int IW  = 6,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [AW-1:0]  cfg_src,
  input  logic [AW-1:0]  cfg_dst,
  input  logic [NW-1:0]  cfg_nbytes,
  input  logic [AW-1:0]  cfg_step,
  input  logic [IW-1:0]  cfg_iter,
  input  logic           cfg_irq_en,
  input  logic           cfg_mnl_en,
  input  logic [CHW-1:0] cfg_mnl_ch,
  input  logic           cfg_mjl_en,
  input  logic [CHW-1:0] cfg_mjl_ch,
  input  logic [CHW-1:0] rd_ch,
  output logic [AW-1:0]  rd_src,
  output logic [AW-1:0]  rd_dst,
  output logic [IW-1:0]  rd_iter,
  input  logic           start,
  input  logic [CHW-1:0] start_ch,
  output logic           busy,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic [31:0]    mem_rdata,
  input  logic           mem_rdy,
  output logic           done_o,
  output logic [CHW-1:0] done_ch,
  output logic           link_o,
  output logic [CHW-1:0] link_ch,
  output logic           err_o,
  output logic [CHW-1:0] err_ch
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_READ, S_WRITE, S_WB, S_POST} st_t;

  logic [AW-1:0]  f_src [NCH];
  logic [AW-1:0]  f_dst [NCH];
  logic [NW-1:0]  f_nb  [NCH];
  logic [AW-1:0]  f_step[NCH];
  logic [IW-1:0]  f_cit [NCH];
  logic [IW-1:0]  f_bit [NCH];
  logic [NCH-1:0] f_irq, f_mnl, f_mjl;
  logic [CHW-1:0] f_mnc [NCH];
  logic [CHW-1:0] f_mjc [NCH];

  st_t           st;
  logic [CHW-1:0] ch;
  logic [AW-1:0]  src, dst;
  logic [NW-1:0]  cnt;
  logic [IW-1:0]  cit;
  logic [31:0]    data;
  logic           fin;

  logic bad;
  assign bad = (f_nb[ch] == '0) || (f_nb[ch][1:0] != 2'b00) || (f_cit[ch] == '0);

  assign busy      = (st != S_IDLE);
  assign mem_req   = (st == S_READ) || (st == S_WRITE);
  assign mem_we    = (st == S_WRITE);
  assign mem_addr  = (st == S_WRITE) ? dst : src;
  assign mem_wdata = data;
  assign rd_src    = f_src[rd_ch];
  assign rd_dst    = f_dst[rd_ch];
  assign rd_iter   = f_cit[rd_ch];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ch <= '0; src <= '0; dst <= '0; cnt <= '0; cit <= '0;
      data <= '0; fin <= 1'b0;
      done_o <= 1'b0; done_ch <= '0; link_o <= 1'b0; link_ch <= '0;
      err_o <= 1'b0; err_ch <= '0;
      f_irq <= '0; f_mnl <= '0; f_mjl <= '0;
      for (int i = 0; i < NCH; i++) begin
        f_src[i] <= '0; f_dst[i] <= '0; f_nb[i] <= '0; f_step[i] <= '0;
        f_cit[i] <= '0; f_bit[i] <= '0; f_mnc[i] <= '0; f_mjc[i] <= '0;
      end
    end else begin
      done_o <= 1'b0;
      link_o <= 1'b0;
      err_o  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          ch <= start_ch;
          st <= S_FETCH;
        end
        S_FETCH: begin
          src <= f_src[ch];
          dst <= f_dst[ch];
          cnt <= f_nb[ch];
          cit <= f_cit[ch];
          if (bad) begin
            err_o  <= 1'b1;
            err_ch <= ch;
            st     <= S_IDLE;
          end else begin
            st <= S_READ;
          end
        end
        S_READ: if (mem_rdy) begin
          data <= mem_rdata;
          st   <= S_WRITE;
        end
        S_WRITE: if (mem_rdy) begin
          src <= src + f_step[ch];
          dst <= dst + f_step[ch];
          cnt <= cnt - NW'(4);
          st  <= (cnt == NW'(4)) ? S_WB : S_READ;
        end
        S_WB: begin
          f_src[ch] <= src;
          f_dst[ch] <= dst;
          f_cit[ch] <= (cit == IW'(1)) ? f_bit[ch] : cit - IW'(1);
          fin       <= (cit == IW'(1));
          link_o    <= f_mnl[ch] && (cit != IW'(1));
          link_ch   <= f_mnc[ch];
          st        <= S_POST;
        end
        S_POST: begin
          done_o  <= fin && f_irq[ch];
          done_ch <= ch;
          if (fin && f_mjl[ch]) begin
            link_o  <= 1'b1;
            link_ch <= f_mjc[ch];
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (cfg_we && st == S_IDLE) begin
        f_src[cfg_ch]  <= cfg_src;
        f_dst[cfg_ch]  <= cfg_dst;
        f_nb[cfg_ch]   <= cfg_nbytes;
        f_step[cfg_ch] <= cfg_step;
        f_cit[cfg_ch]  <= cfg_iter;
        f_bit[cfg_ch]  <= cfg_iter;
        f_irq[cfg_ch]  <= cfg_irq_en;
        f_mnl[cfg_ch]  <= cfg_mnl_en;
        f_mnc[cfg_ch]  <= cfg_mnl_ch;
        f_mjl[cfg_ch]  <= cfg_mjl_en;
        f_mjc[cfg_ch]  <= cfg_mjl_ch;
      end
    end
  end

  // R1
  first_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !mem_req);
  // R2
  err_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!mem_req && !busy));
  // R4
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rdy && !mem_we) |=> (mem_req && mem_we));
  // R5
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R8
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy && !err_o));
endmodule

// File: tb/dma_desc_seq_tb.sv
module dma_desc_seq_tb;
  localparam int NCH = 4, AW = 16, NW = 10, IW = 6, CHW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cfg_we = 0, cfg_irq_en = 0, cfg_mnl_en = 0, cfg_mjl_en = 0;
  logic [CHW-1:0] cfg_ch = 0, cfg_mnl_ch = 0, cfg_mjl_ch = 0, rd_ch = 0, start_ch = 0;
  logic [AW-1:0] cfg_src = 0, cfg_dst = 0, cfg_step = 0;
  logic [NW-1:0] cfg_nbytes = 0;
  logic [IW-1:0] cfg_iter = 0;
  logic start = 0;
  logic [AW-1:0] rd_src, rd_dst, mem_addr;
  logic [IW-1:0] rd_iter;
  logic busy, mem_req, mem_we, mem_rdy, done_o, link_o, err_o;
  logic [31:0] mem_wdata, mem_rdata;
  logic [CHW-1:0] done_ch, link_ch, err_ch;

  dma_desc_seq #(.NCH(NCH), .AW(AW), .NW(NW), .IW(IW)) u_dut (
    .clk, .rst_n, .cfg_we, .cfg_ch, .cfg_src, .cfg_dst, .cfg_nbytes, .cfg_step,
    .cfg_iter, .cfg_irq_en, .cfg_mnl_en, .cfg_mnl_ch, .cfg_mjl_en, .cfg_mjl_ch,
    .rd_ch, .rd_src, .rd_dst, .rd_iter, .start, .start_ch, .busy, .mem_req,
    .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_rdy, .done_o, .done_ch,
    .link_o, .link_ch, .err_o, .err_ch);

  logic [31:0] mem [256];
  logic stall_mode = 0, phase = 0;
  assign mem_rdy   = mem_req && (!stall_mode || phase);
  assign mem_rdata = mem[mem_addr[9:2]];

  int n_done = 0, n_link = 0, n_err = 0, n_rd = 0, n_wr = 0, n_viol = 0;
  logic [CHW-1:0] l_done, l_link, l_err;
  logic p_req = 0, p_rdy = 0, p_we = 0;
  logic [AW-1:0] p_addr = 0;
  always @(posedge clk) begin
    phase <= ~phase;
    if (mem_req && mem_rdy && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (mem_req && mem_rdy) begin if (mem_we) n_wr++; else n_rd++; end
    if (p_req && !p_rdy && (!mem_req || mem_addr != p_addr || mem_we != p_we)) n_viol++;
    p_req <= mem_req; p_rdy <= mem_rdy; p_addr <= mem_addr; p_we <= mem_we;
    if (done_o) begin n_done++; l_done = done_ch; end
    if (link_o) begin n_link++; l_link = link_ch; end
    if (err_o)  begin n_err++;  l_err = err_ch; end
  end

  int checks = 0, errors = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    n_done = 0; n_link = 0; n_err = 0; n_rd = 0; n_wr = 0;
  endtask

  task automatic cfg(input int c, input int s, input int d, input int nb, input int st,
                     input int it, input bit irq, input bit mne, input int mnc,
                     input bit mje, input int mjc);
    @(negedge clk);
    cfg_we = 1; cfg_ch = CHW'(c); cfg_src = AW'(s); cfg_dst = AW'(d);
    cfg_nbytes = NW'(nb); cfg_step = AW'(st); cfg_iter = IW'(it);
    cfg_irq_en = irq; cfg_mnl_en = mne; cfg_mnl_ch = CHW'(mnc);
    cfg_mjl_en = mje; cfg_mjl_ch = CHW'(mjc);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run(input int c, output int bcyc);
    bit saw_busy;
    clr();
    @(negedge clk);
    start = 1; start_ch = CHW'(c);
    @(negedge clk);
    start = 0;
    saw_busy = busy;
    bcyc = 0;
    while (busy) begin @(negedge clk); bcyc++; end
    if (!saw_busy) bcyc = -1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic readback(input int c, input string tag, input int s, input int d, input int it);
    rd_ch = CHW'(c);
    #1;
    chk({tag, " src"}, 32'(rd_src), s);
    chk({tag, " dst"}, 32'(rd_dst), d);
    chk({tag, " iter"}, 32'(rd_iter), it);
  endtask

  task automatic t_reset();
    chk("R1 reset busy", busy, 0);
    chk("R1 reset req", mem_req, 0);
    chk("R9 reset done/link/err", {done_o, link_o, err_o}, 0);
  endtask

  task automatic t_basic();
    int b;
    cfg(1, 'h100, 'h200, 8, 4, 2, 1, 1, 3, 1, 2);
    run(1, b);
    chk("R1 busy seen", 32'(b > 0), 1);
    chk("R4 reads", n_rd, 2);
    chk("R4 writes", n_wr, 2);
    chk("R4 data w0", mem['h80], mem['h40]);
    chk("R4 data w1", mem['h81], mem['h41]);
    readback(1, "R6 pass1", 'h108, 'h208, 1);
    chk("R7 minor link count", n_link, 1);
    chk("R7 minor link ch", l_link, 3);
    chk("R7 no done", n_done, 0);
    run(1, b);
    chk("R4 data w2", mem['h82], mem['h42]);
    chk("R4 data w3", mem['h83], mem['h43]);
    readback(1, "R8 reload", 'h110, 'h210, 2);
    chk("R8 done count", n_done, 1);
    chk("R8 done ch", l_done, 1);
    chk("R8 major link only", n_link, 1);
    chk("R8 major link ch", l_link, 2);
  endtask

  task automatic t_err();
    int b;
    cfg(2, 'h20, 'h40, 6, 4, 3, 1, 1, 0, 1, 0);
    for (int k = 0; k < 2; k++) begin
      run(2, b);
      chk(k == 0 ? "R2 err count" : "R3 err again", n_err, 1);
      chk("R2 err ch", l_err, 2);
      chk("R2 no access", n_rd + n_wr, 0);
      chk("R2 no done/link", n_done + n_link, 0);
    end
    readback(2, "R2 unchanged", 'h20, 'h40, 3);
    cfg(0, 'h20, 'h40, 0, 4, 1, 0, 0, 0, 0, 0);
    run(0, b);
    chk("R2 zero bytes err", n_err, 1);
    chk("R2 zero bytes ch", l_err, 0);
    cfg(3, 'h20, 'h40, 4, 4, 0, 0, 0, 0, 0, 0);
    run(3, b);
    chk("R2 zero iter err", n_err, 1);
    chk("R2 zero iter no access", n_rd + n_wr, 0);
  endtask

  task automatic t_step_stall();
    int b;
    logic [31:0] keep;
    keep = mem['hE1];
    stall_mode = 1;
    cfg(0, 'h300, 'h380, 12, 8, 1, 0, 0, 1, 0, 2);
    run(0, b);
    stall_mode = 0;
    chk("R4 step w0", mem['hE0], mem['hC0]);
    chk("R4 step w1", mem['hE2], mem['hC2]);
    chk("R4 step w2", mem['hE4], mem['hC4]);
    chk("R4 gap untouched", mem['hE1], keep);
    chk("R4 pair count", n_wr, 3);
    chk("R5 held under stall", n_viol, 0);
    readback(0, "R6 step", 'h318, 'h398, 1);
    chk("R9 no done/link", n_done + n_link, 0);
  endtask

  task automatic t_start_busy();
    int b;
    cfg(3, 'h000, 'h3C0, 8, 4, 1, 1, 0, 0, 0, 0);
    clr();
    @(negedge clk); start = 1; start_ch = 3;
    @(negedge clk); start_ch = 2;
    @(negedge clk); start = 0;
    while (busy) @(negedge clk);
    @(negedge clk); @(negedge clk);
    chk("R1 start while busy ignored", n_err, 0);
    chk("R1 single done", n_done, 1);
    chk("R1 done ch", l_done, 3);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 + i;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_basic();
    t_err();
    t_step_stall();
    t_start_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule